// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block sits between a bus master and external memories or peripherals. Each bus request carries the upper address bits and a direction. The block compares them against three programmable windows, drives one active-low select for the winning window and holds it for a programmable number of wait states. It then returns a one-cycle transfer acknowledge. The external data port behind every window is 16 bits wide. The block carries no data, only the control strobes.

Windows 0 and 1 drive a plain select. For reads they also pull a shared output-enable low, and both windows share one buffer enable. Window 2 serves an AT-bus style device. Instead of a select it drives separate read and write strobes, uses its own buffer enable, and keeps a cycle open while the device's ready input is low.

Out of reset only window 0 is live, and it matches every address so that a boot memory can sit anywhere. A strap input is captured while reset is high. When the strap is high, window 0 drives the external boot select. When it is low, window 0 drives the on-chip boot ROM select instead, and the external select stays idle.

Top module: `csel_ctrl`

## Requirements
- R1: After reset, window 0 is valid, has an all-ones mask, allows reads and writes and has 15 wait states, so every request selects it. Windows 1 and 2 are invalid. While reset is high, all strobes are high and ack_o is low.
- R2: boot_strap_i is captured while rst is high. If it was 1, window 0 cycles drive cs_n_o[0] low and rom_sel_n_o stays high. If it was 0, they drive rom_sel_n_o low and cs_n_o[0] stays high.
- R3: The configuration is written with reg_we_i, reg_cs_i (window 0..2; index 3 is ignored), reg_field_i and reg_wdata_i.
  - reg_field_i selects the field: 0 = base tag, 1 = mask, 2 = control.
  - Control word bits: bit 0 = valid, bit 1 = read enable, bit 2 = write enable, bits 7:4 = wait count.
  - A write affects only requests sampled on later clocks.
- R4: A window hits when all three hold: it is valid; ((addr_hi_i ^ base) & ~mask) == 0, so a mask bit of 1 ignores that address bit; and its enable bit for the request direction (wr_i) is set.
- R5: When several windows hit, the lowest-numbered one wins. When none hits, no strobe asserts and ack_o stays low for as long as req_i is held.
- R6: A hit sampled in idle asserts the window's strobe from the next cycle. A window with wait count W holds the strobe for W+2 cycles when ready permits, and ack_o is high in the last of them. ack_o lasts one cycle, and all strobes are high in the cycle after it.
- R7: A window 2 cycle drives rd_strb_n_o low for reads and wr_strb_n_o low for writes, never cs_n_o or oe_n_o. After its wait count has elapsed, each cycle with ready_i low adds one more cycle before ack_o.
- R8: oe_n_o is low exactly during read cycles of window 0 or 1.
- R9: be_n_o[0] is low during any window 0 or 1 cycle, and be_n_o[1] is low during any window 2 cycle.
- R10: At most one of cs_n_o[0], cs_n_o[1], rom_sel_n_o, rd_strb_n_o and wr_strb_n_o is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap_i | input | 1 | Boot role strap, captured during reset |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_cs_i | input | 2 | Window index of the write |
| reg_field_i | input | 2 | Field code: 0 base, 1 mask, 2 control |
| reg_wdata_i | input | 16 | Configuration write data |
| req_i | input | 1 | Bus request, held until ack_o |
| addr_hi_i | input | 16 | Address bits 31:16 of the request |
| wr_i | input | 1 | Request direction, 1 = write |
| ready_i | input | 1 | Device ready for window 2 |
| cs_n_o | output | 2 | Active-low selects of windows 0 and 1 |
| rom_sel_n_o | output | 1 | Active-low on-chip boot ROM select |
| rd_strb_n_o | output | 1 | Active-low window 2 read strobe |
| wr_strb_n_o | output | 1 | Active-low window 2 write strobe |
| oe_n_o | output | 1 | Active-low shared output enable |
| be_n_o | output | 2 | Active-low buffer enables |
| ack_o | output | 1 | One-cycle transfer acknowledge |

## Verification
A configuration write and the start of a cycle can fall in the same clock. The window being programmed may be the one the request is decoded against. The bench provokes this by raising req_i in the same cycle as a write that removes read permission from the hitting window. It also provokes a write that would create a higher-priority hit. The cycle-level reference model decodes with the configuration held before that edge, so the cycle must go to the window chosen by the old configuration. The later request must then see the new one.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int NUM_CS  = 3;
    localparam int ADDR_W  = 32;
    localparam int BLK_LSB = 16;
    localparam int TAG_W   = ADDR_W - BLK_LSB;
    localparam int WAIT_W  = 4;
    localparam int CFG_W   = 16;
    localparam int IDX_W   = $clog2(NUM_CS);
    localparam int RDY_CS  = 2;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2
    } field_e;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              wen;
        logic              ren;
        logic              valid;
    } ctrl_t;

    typedef struct packed {
        logic [TAG_W-1:0] base;
        logic [TAG_W-1:0] mask;
        ctrl_t            ctrl;
    } cs_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [WAIT_W-1:0] waits;
    } pick_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;

    function automatic ctrl_t word_to_ctrl(logic [7:0] w);
        ctrl_t c;
        c.valid = w[0];
        c.ren   = w[1];
        c.wen   = w[2];
        c.waits = w[7:4];
        return c;
    endfunction

    function automatic cs_cfg_t reset_cfg(int unsigned i);
        cs_cfg_t c;
        c = '0;
        if (i == 0) begin
            c.mask       = '1;
            c.ctrl.valid = 1'b1;
            c.ctrl.ren   = 1'b1;
            c.ctrl.wen   = 1'b1;
            c.ctrl.waits = '1;
        end
        return c;
    endfunction

endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int NUM = NUM_CS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [1:0]           cs_i,
    input  logic [1:0]           field_i,
    input  logic [CFG_W-1:0]     wdata_i,
    output cs_cfg_t [NUM-1:0]    cfg_o
);

    for (genvar g = 0; g < NUM; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[g] <= reset_cfg(g);
            end else if (we_i && (cs_i == 2'(g))) begin
                case (field_e'(field_i))
                    FLD_BASE: cfg_o[g].base <= wdata_i[TAG_W-1:0];
                    FLD_MASK: cfg_o[g].mask <= wdata_i[TAG_W-1:0];
                    FLD_CTRL: cfg_o[g].ctrl <= word_to_ctrl(wdata_i[7:0]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int NUM = NUM_CS
) (
    input  cs_cfg_t [NUM-1:0]   cfg_i,
    input  logic [TAG_W-1:0]    tag_i,
    input  logic                write_i,
    output pick_t               pick_o
);

    logic [NUM-1:0] hit;

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        logic tag_ok;
        logic dir_ok;
        assign tag_ok = (((tag_i ^ cfg_i[g].base) & ~cfg_i[g].mask) == '0);
        assign dir_ok = write_i ? cfg_i[g].ctrl.wen : cfg_i[g].ctrl.ren;
        assign hit[g] = cfg_i[g].ctrl.valid && tag_ok && dir_ok;
    end

    // Scan from the top so the lowest index is written last and wins.
    always_comb begin
        pick_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick_o.hit   = 1'b1;
                pick_o.idx   = IDX_W'(i);
                pick_o.waits = cfg_i[i].ctrl.waits;
            end
        end
    end

endmodule

// File: rtl/csel_seq.sv
module csel_seq
    import csel_pkg::*;
#(
    parameter int RDY_IDX = RDY_CS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             write_i,
    input  pick_t            pick_i,
    input  logic             ready_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             write_o
);

    logic [WAIT_W-1:0] cnt;
    logic              needs_ready;

    assign needs_ready = (idx_o == IDX_W'(RDY_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            idx_o   <= '0;
            write_o <= 1'b0;
            cnt     <= '0;
        end else begin
            case (phase_o)
                PH_IDLE: begin
                    if (req_i && pick_i.hit) begin
                        phase_o <= PH_WAIT;
                        idx_o   <= pick_i.idx;
                        write_o <= write_i;
                        cnt     <= pick_i.waits;
                    end
                end
                PH_WAIT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!needs_ready || ready_i) begin
                        phase_o <= PH_ACK;
                    end
                end
                PH_ACK:  phase_o <= PH_IDLE;
                default: phase_o <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      boot_strap_i,
    input  logic                      reg_we_i,
    input  logic [1:0]                reg_cs_i,
    input  logic [1:0]                reg_field_i,
    input  logic [CFG_W-1:0]          reg_wdata_i,
    input  logic                      req_i,
    input  logic [ADDR_W-1:BLK_LSB]   addr_hi_i,
    input  logic                      wr_i,
    input  logic                      ready_i,
    output logic [1:0]                cs_n_o,
    output logic                      rom_sel_n_o,
    output logic                      rd_strb_n_o,
    output logic                      wr_strb_n_o,
    output logic                      oe_n_o,
    output logic [1:0]                be_n_o,
    output logic                      ack_o
);

    cs_cfg_t [NUM_CS-1:0] cfg;
    pick_t                pick;
    phase_e               phase;
    logic [IDX_W-1:0]     cur_idx;
    logic                 cur_wr;
    logic                 strap_q;
    logic                 live;
    logic [NUM_CS-1:0]    sel;

    csel_regs #(.NUM(NUM_CS)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we_i),
        .cs_i    (reg_cs_i),
        .field_i (reg_field_i),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg)
    );

    csel_decode #(.NUM(NUM_CS)) i_decode (
        .cfg_i   (cfg),
        .tag_i   (addr_hi_i),
        .write_i (wr_i),
        .pick_o  (pick)
    );

    csel_seq #(.RDY_IDX(RDY_CS)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .write_i (wr_i),
        .pick_i  (pick),
        .ready_i (ready_i),
        .phase_o (phase),
        .idx_o   (cur_idx),
        .write_o (cur_wr)
    );

    // The strap is only looked at while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= boot_strap_i;
        end
    end

    assign live = (phase != PH_IDLE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign sel[g] = live && (cur_idx == IDX_W'(g));
    end

    assign cs_n_o[0]   = !(sel[0] && strap_q);
    assign rom_sel_n_o = !(sel[0] && !strap_q);
    assign cs_n_o[1]   = !sel[1];
    assign rd_strb_n_o = !(sel[RDY_CS] && !cur_wr);
    assign wr_strb_n_o = !(sel[RDY_CS] && cur_wr);
    assign oe_n_o      = !((sel[0] || sel[1]) && !cur_wr);
    assign be_n_o[0]   = !(sel[0] || sel[1]);
    assign be_n_o[1]   = !sel[RDY_CS];
    assign ack_o       = (phase == PH_ACK);

endmodule

// File: rtl/csel_ctrl_chk.sv
module csel_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       ready_i,
    input logic [1:0] cs_n_o,
    input logic       rom_sel_n_o,
    input logic       rd_strb_n_o,
    input logic       wr_strb_n_o,
    input logic       oe_n_o,
    input logic [1:0] be_n_o,
    input logic       ack_o
);

    logic any_strobe;
    logic ide_strobe;
    assign any_strobe = !cs_n_o[0] || !cs_n_o[1] || !rom_sel_n_o || !rd_strb_n_o || !wr_strb_n_o;
    assign ide_strobe = !rd_strb_n_o || !wr_strb_n_o;

    assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~cs_n_o, ~rom_sel_n_o, ~rd_strb_n_o, ~wr_strb_n_o}))
        else $error("more than one select low");

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o)
        else $error("ack longer than one cycle");

    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !any_strobe)
        else $error("strobe held past ack");

    assert_ack_inside_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> any_strobe)
        else $error("ack without an active strobe");

    assert_ready_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (ide_strobe && !ready_i && !ack_o) |=> !ack_o)
        else $error("window 2 acked while not ready");

    assert_oe_scope_R8: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> (!cs_n_o[0] || !cs_n_o[1] || !rom_sel_n_o))
        else $error("output enable outside window 0/1");

    assert_be_split_R9: assert property (@(posedge clk) disable iff (rst)
        (ide_strobe |-> (!be_n_o[1] && be_n_o[0])))
        else $error("wrong buffer enable for window 2");

    assert_start_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(any_strobe) |-> $past(req_i))
        else $error("cycle started without a request");

endmodule

bind csel_ctrl csel_ctrl_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .ready_i     (ready_i),
    .cs_n_o      (cs_n_o),
    .rom_sel_n_o (rom_sel_n_o),
    .rd_strb_n_o (rd_strb_n_o),
    .wr_strb_n_o (wr_strb_n_o),
    .oe_n_o      (oe_n_o),
    .be_n_o      (be_n_o),
    .ack_o       (ack_o)
);

// File: tb/test_csel_ctrl.sv
module test_csel_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_strap_i = 1'b1;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_cs_i = '0;
    logic [1:0]  reg_field_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic        req_i = 1'b0;
    logic [15:0] addr_hi_i = '0;
    logic        wr_i = 1'b0;
    logic        ready_i = 1'b1;
    logic [1:0]  cs_n_o;
    logic        rom_sel_n_o, rd_strb_n_o, wr_strb_n_o, oe_n_o, ack_o;
    logic [1:0]  be_n_o;

    always #5 clk = ~clk;

    csel_ctrl i_csel_ctrl (
        .clk(clk), .rst(rst), .boot_strap_i(boot_strap_i),
        .reg_we_i(reg_we_i), .reg_cs_i(reg_cs_i), .reg_field_i(reg_field_i),
        .reg_wdata_i(reg_wdata_i), .req_i(req_i), .addr_hi_i(addr_hi_i),
        .wr_i(wr_i), .ready_i(ready_i), .cs_n_o(cs_n_o), .rom_sel_n_o(rom_sel_n_o),
        .rd_strb_n_o(rd_strb_n_o), .wr_strb_n_o(wr_strb_n_o), .oe_n_o(oe_n_o),
        .be_n_o(be_n_o), .ack_o(ack_o)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;
    string cur_req = "R1 reset state";

    // Behavioural reference model.
    logic [15:0] m_base [3];
    logic [15:0] m_mask [3];
    bit          m_val [3];
    bit          m_ren [3];
    bit          m_wen [3];
    int          m_wait [3];
    bit          m_strap, m_busy, m_ack, m_wr;
    int          m_sel, m_elapsed, m_limit;

    function automatic bit m_hit(int k);
        bit tag_ok;
        tag_ok = (((addr_hi_i ^ m_base[k]) & ~m_mask[k]) == 16'h0);
        return m_val[k] && tag_ok && (wr_i ? m_wen[k] : m_ren[k]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_strap = boot_strap_i;
            m_busy  = 0;
            m_ack   = 0;
            for (int k = 0; k < 3; k++) begin
                m_base[k] = 16'h0;
                m_mask[k] = (k == 0) ? 16'hFFFF : 16'h0;
                m_val[k]  = (k == 0);
                m_ren[k]  = (k == 0);
                m_wen[k]  = (k == 0);
                m_wait[k] = (k == 0) ? 15 : 0;
            end
        end else begin
            if (m_ack) begin
                m_ack  = 0;
                m_busy = 0;
            end else if (m_busy) begin
                if (m_elapsed <= m_limit) m_elapsed++;
                else if (m_sel != 2 || ready_i) m_ack = 1;
            end else if (req_i) begin
                m_sel = -1;
                for (int k = 2; k >= 0; k--) if (m_hit(k)) m_sel = k;
                if (m_sel >= 0) begin
                    m_busy    = 1;
                    m_wr      = wr_i;
                    m_elapsed = 1;
                    m_limit   = m_wait[m_sel];
                end
            end
            if (reg_we_i && reg_cs_i != 2'd3) begin
                case (reg_field_i)
                    2'd0: m_base[reg_cs_i] = reg_wdata_i;
                    2'd1: m_mask[reg_cs_i] = reg_wdata_i;
                    2'd2: begin
                        m_val[reg_cs_i]  = reg_wdata_i[0];
                        m_ren[reg_cs_i]  = reg_wdata_i[1];
                        m_wen[reg_cs_i]  = reg_wdata_i[2];
                        m_wait[reg_cs_i] = int'(reg_wdata_i[7:4]);
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        logic [1:0] e_cs, e_be;
        logic e_rom, e_rd, e_wr, e_oe;
        int lows;
        e_cs = 2'b11; e_be = 2'b11; e_rom = 1; e_rd = 1; e_wr = 1; e_oe = 1;
        if (m_busy) begin
            case (m_sel)
                0: begin
                    if (m_strap) e_cs[0] = 0; else e_rom = 0;
                    e_be[0] = 0; e_oe = m_wr;
                end
                1: begin e_cs[1] = 0; e_be[0] = 0; e_oe = m_wr; end
                default: begin
                    if (m_wr) e_wr = 0; else e_rd = 0;
                    e_be[1] = 0;
                end
            endcase
        end
        compared++;
        if ({cs_n_o, rom_sel_n_o, rd_strb_n_o, wr_strb_n_o, oe_n_o, be_n_o, ack_o} !==
            {e_cs, e_rom, e_rd, e_wr, e_oe, e_be, m_ack}) begin
            mismatched++;
            $display("FAIL %s t=%0t: got cs=%b rom=%b rd=%b wr=%b oe=%b be=%b ack=%b, expected cs=%b rom=%b rd=%b wr=%b oe=%b be=%b ack=%b",
                cur_req, $time, cs_n_o, rom_sel_n_o, rd_strb_n_o, wr_strb_n_o, oe_n_o, be_n_o, ack_o,
                e_cs, e_rom, e_rd, e_wr, e_oe, e_be, m_ack);
        end
        lows = int'(!cs_n_o[0]) + int'(!cs_n_o[1]) + int'(!rom_sel_n_o) + int'(!rd_strb_n_o) + int'(!wr_strb_n_o);
        compared++;
        if (lows > 1) begin
            mismatched++;
            $display("FAIL R10 t=%0t: %0d selects low, expected at most 1", $time, lows);
        end
    end

    task automatic do_reset(bit strap);
        @(negedge clk);
        boot_strap_i = strap;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        boot_strap_i = ~strap;
    endtask

    task automatic wr_reg(int cs, int fld, logic [15:0] d);
        @(negedge clk);
        reg_we_i = 1; reg_cs_i = 2'(cs); reg_field_i = 2'(fld); reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 0;
    endtask

    task automatic access(logic [15:0] a, bit w, int rdy_low, int max_cyc);
        @(negedge clk);
        addr_hi_i = a; wr_i = w; req_i = 1; ready_i = (rdy_low == 0);
        for (int n = 0; n < max_cyc; n++) begin
            @(negedge clk);
            if (n + 1 >= rdy_low) ready_i = 1;
            if (ack_o) break;
        end
        req_i = 0;
        ready_i = 1;
    endtask

    // Request and configuration write land on the same clock edge.
    task automatic access_with_write(logic [15:0] a, bit w, int cs, int fld, logic [15:0] d);
        @(negedge clk);
        addr_hi_i = a; wr_i = w; req_i = 1;
        reg_we_i = 1; reg_cs_i = 2'(cs); reg_field_i = 2'(fld); reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 0;
        for (int n = 0; n < 40; n++) begin
            if (ack_o) break;
            @(negedge clk);
        end
        req_i = 0;
    endtask

    initial begin
        cur_req = "R1 reset state";
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        cur_req = "R1 R2 boot window read";
        access(16'h1234, 0, 0, 40);
        cur_req = "R1 R6 boot window write";
        access(16'hFFFF, 1, 0, 40);
        cur_req = "R1 disabled windows";
        access(16'h0000, 0, 0, 40);

        cur_req = "R3 programming";
        wr_reg(0, 1, 16'h000F);
        wr_reg(0, 2, 16'h0027);
        wr_reg(1, 0, 16'h0010);
        wr_reg(1, 1, 16'h0000);
        wr_reg(1, 2, 16'h0003);
        wr_reg(2, 0, 16'h0100);
        wr_reg(2, 1, 16'h00FF);
        wr_reg(2, 2, 16'h0017);
        wr_reg(3, 2, 16'h00F7);
        cur_req = "R4 R8 window 0 masked read";
        access(16'h0005, 0, 0, 40);
        cur_req = "R4 R6 window 1 zero waits";
        access(16'h0010, 0, 0, 40);
        cur_req = "R4 window 1 write disabled";
        access(16'h0010, 1, 0, 6);
        cur_req = "R5 no window hit";
        access(16'h0200, 0, 0, 6);
        cur_req = "R7 R9 window 2 read with ready low";
        access(16'h0123, 0, 4, 40);
        cur_req = "R7 R9 window 2 write";
        access(16'h01FE, 1, 0, 40);
        cur_req = "R7 window 2 ready held low long";
        access(16'h0100, 0, 9, 40);

        cur_req = "R5 overlap lowest index wins";
        wr_reg(1, 0, 16'h0000);
        wr_reg(1, 1, 16'h000F);
        wr_reg(1, 2, 16'h0017);
        access(16'h0003, 0, 0, 40);
        cur_req = "R5 window 0 disabled";
        wr_reg(0, 2, 16'h0026);
        access(16'h0003, 1, 0, 40);

        cur_req = "R3 write coincides with request";
        access_with_write(16'h0003, 0, 1, 2, 16'h0015);
        cur_req = "R3 new control after same-cycle write";
        access(16'h0003, 0, 0, 6);
        access_with_write(16'h0003, 1, 0, 2, 16'h0027);
        access(16'h0003, 1, 0, 40);

        cur_req = "R2 strap low selects boot ROM";
        do_reset(1'b0);
        access(16'hABCD, 0, 0, 40);
        access(16'h0001, 1, 0, 40);
        cur_req = "R1 R8 after second reset";
        access(16'h0000, 0, 0, 40);
        repeat (3) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule